// File: doc/BRIEF.md
# Nibble Accumulator Processor Core

This block is a minimal single-cycle processor built around a 4-bit accumulator. It fetches an 8-bit instruction every clock from a program ROM and acts on a data RAM. Both memories sit outside the core, which drives their addresses. Each instruction word holds an opcode in its upper four bits and a 4-bit constant in its lower four bits. Seven operations exist: load, add, subtract, store, read, jump and jump-if-zero. Each comes in two flavours. The constant flavour uses the embedded constant as its operand. The memory flavour uses the RAM word found at the latched data address.

The latched data address can only be set by the read operation. A program therefore places a read in front of each instruction that needs a memory operand. Typical use is a small teaching machine: a short loop such as "read 2, load memory, add 1, store to 2, jump to 0" increments a RAM cell forever. The core holds the program counter, the accumulator and the data address register. It decodes the opcode and sequences one instruction per clock. RAM reads are combinational and RAM writes are synchronous.

Top module: `nacc_core`

## Requirements
- R1: The opcode is instruction bits 7:4 and the constant is bits 3:0. Opcode bits 3:1 pick the operation: 000 load, 001 add, 010 subtract, 011 store, 100 read, 101 jump, 110 jump-if-zero, 111 no-operation. When opcode bit 0 is 1, the operand is the RAM word at the latched address; when it is 0, the operand is the constant.
- R2: Load places the operand in the accumulator.
- R3: Add sets the accumulator to accumulator plus operand, modulo 16.
- R4: Subtract sets the accumulator to accumulator minus operand, modulo 16.
- R5: Store asserts the RAM write enable in the same cycle, with the current accumulator as write data and the operand as write address. For the memory flavour, the write address is therefore the RAM word at the latched address. No other operation writes RAM.
- R6: Read latches the operand into the data address register, which drives the RAM read address from the next cycle on. No other operation changes that register.
- R7: Jump loads the program counter with the operand.
- R8: Jump-if-zero loads the program counter with the operand when the accumulator is zero. Otherwise it advances the program counter by one.
- R9: Opcodes 1110 and 1111 change no state. Every operation other than the two jumps advances the program counter by one, modulo 16.
- R10: A synchronous active-high reset clears the program counter, the accumulator and the data address register, and suppresses RAM writes while it is asserted.
- R11: The memory flavour ignores the constant field entirely.
- R12: The five-instruction increment loop adds one, modulo 16, to RAM word 2 on every pass of five cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | 4 | Program counter, used as the ROM address |
| rom_data | input | 8 | Instruction word fetched from ROM |
| ram_raddr | output | 4 | RAM read address, taken from the data address register |
| ram_rdata | input | 4 | RAM word at ram_raddr, read combinationally |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | 4 | RAM write address |
| ram_wdata | output | 4 | RAM write data, the accumulator |

## Verification
The write enable, write address and write data of a store belong to the cycle in which the store is fetched, so they are due before the next rising edge. The program counter and the read address reflect an instruction one edge after it executes. The accumulator becomes visible only through the write data of a later store. The bench keeps a behavioural model of state and RAM. On every falling edge it compares the model's program counter, read address and expected write port against the design, so each result is sampled half a cycle after the edge that produced it. The RAM cells a program leaves behind are also checked against hand-computed values.

// File: rtl/nacc_pkg.sv
package nacc_pkg;

    // Arithmetic selection for the accumulator path.
    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_ADD  = 2'd1,
        ALU_SUB  = 2'd2
    } alu_sel_e;

    // Operation class, taken from opcode bits 3:1.
    typedef enum logic [2:0] {
        OPC_LOAD  = 3'b000,
        OPC_ADD   = 3'b001,
        OPC_SUB   = 3'b010,
        OPC_STORE = 3'b011,
        OPC_READ  = 3'b100,
        OPC_JUMP  = 3'b101,
        OPC_JZERO = 3'b110,
        OPC_IDLE  = 3'b111
    } op_class_e;

    // Decoded control bundle.
    typedef struct packed {
        logic     use_mem;
        logic     acc_wr;
        alu_sel_e alu_sel;
        logic     st_en;
        logic     adr_wr;
        logic     pc_jump;
        logic     pc_cond;
    } ctrl_t;

endpackage

// File: rtl/nacc_decode.sv
module nacc_decode
    import nacc_pkg::*;
(
    input  logic [3:0] opcode,
    output ctrl_t      ctrl
);

    op_class_e cls;

    always_comb begin
        cls          = op_class_e'(opcode[3:1]);
        ctrl         = '0;
        ctrl.alu_sel = ALU_PASS;
        ctrl.use_mem = opcode[0];
        unique case (cls)
            OPC_LOAD: begin
                ctrl.acc_wr  = 1'b1;
                ctrl.alu_sel = ALU_PASS;
            end
            OPC_ADD: begin
                ctrl.acc_wr  = 1'b1;
                ctrl.alu_sel = ALU_ADD;
            end
            OPC_SUB: begin
                ctrl.acc_wr  = 1'b1;
                ctrl.alu_sel = ALU_SUB;
            end
            OPC_STORE: ctrl.st_en   = 1'b1;
            OPC_READ:  ctrl.adr_wr  = 1'b1;
            OPC_JUMP:  ctrl.pc_jump = 1'b1;
            OPC_JZERO: ctrl.pc_cond = 1'b1;
            default:   ctrl.use_mem = 1'b0;
        endcase
    end

endmodule

// File: rtl/nacc_alu.sv
module nacc_alu
    import nacc_pkg::*;
#(
    parameter int DW = 4
) (
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    input  alu_sel_e      sel,
    output logic [DW-1:0] y
);

    always_comb begin
        unique case (sel)
            ALU_ADD: y = acc + opnd;
            ALU_SUB: y = acc - opnd;
            default: y = opnd;
        endcase
    end

endmodule

// File: rtl/nacc_pc_next.sv
module nacc_pc_next #(
    parameter int PW = 4,
    parameter int DW = 4
) (
    input  logic [PW-1:0] pc_q,
    input  logic [DW-1:0] target,
    input  logic          jump,
    input  logic          cond,
    input  logic          acc_zero,
    output logic [PW-1:0] pc_d
);

    logic [PW-1:0] tgt;

    // Fit the data-width target to the program counter width.
    generate
        if (PW > DW) begin : g_widen
            assign tgt = {{(PW-DW){1'b0}}, target};
        end else if (PW == DW) begin : g_same
            assign tgt = target;
        end else begin : g_narrow
            assign tgt = target[PW-1:0];
        end
    endgenerate

    always_comb begin
        if (jump || (cond && acc_zero)) begin
            pc_d = tgt;
        end else begin
            pc_d = pc_q + PW'(1);
        end
    end

endmodule

// File: rtl/nacc_core.sv
module nacc_core
    import nacc_pkg::*;
#(
    parameter int DW = 4,
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] rom_addr,
    input  logic [DW+3:0] rom_data,
    output logic [DW-1:0] ram_raddr,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_we,
    output logic [DW-1:0] ram_waddr,
    output logic [DW-1:0] ram_wdata
);

    localparam int IW = DW + 4;

    typedef struct packed {
        logic [PW-1:0] pc;
        logic [DW-1:0] acc;
        logic [DW-1:0] adr;
    } core_st_t;

    core_st_t      st_d, st_q;
    ctrl_t         ctrl;
    logic [3:0]    opcode;
    logic [DW-1:0] kval;
    logic [DW-1:0] opnd;
    logic [DW-1:0] alu_y;
    logic [PW-1:0] pc_nx;
    logic          acc_zero;

    assign opcode   = rom_data[IW-1:DW];
    assign kval     = rom_data[DW-1:0];
    assign opnd     = ctrl.use_mem ? ram_rdata : kval;
    assign acc_zero = (st_q.acc == '0);

    nacc_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    nacc_alu #(.DW(DW)) u_alu (
        .acc  (st_q.acc),
        .opnd (opnd),
        .sel  (ctrl.alu_sel),
        .y    (alu_y)
    );

    nacc_pc_next #(.PW(PW), .DW(DW)) u_pcn (
        .pc_q     (st_q.pc),
        .target   (opnd),
        .jump     (ctrl.pc_jump),
        .cond     (ctrl.pc_cond),
        .acc_zero (acc_zero),
        .pc_d     (pc_nx)
    );

    always_comb begin
        st_d    = st_q;
        st_d.pc = pc_nx;
        if (ctrl.acc_wr) begin
            st_d.acc = alu_y;
        end
        if (ctrl.adr_wr) begin
            st_d.adr = opnd;
        end
        rom_addr  = st_q.pc;
        ram_raddr = st_q.adr;
        ram_we    = ctrl.st_en & ~rst;
        ram_waddr = opnd;
        ram_wdata = st_q.acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/nacc_chk.sv
module nacc_chk #(
    parameter int DW = 4,
    parameter int PW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [PW-1:0] rom_addr,
    input logic [DW+3:0] rom_data,
    input logic [DW-1:0] ram_raddr,
    input logic          ram_we,
    input logic [DW-1:0] ram_waddr
);

    logic [3:0]    op;
    logic [DW-1:0] k;
    assign op = rom_data[DW+3:DW];
    assign k  = rom_data[DW-1:0];

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (rom_addr == '0 && ram_raddr == '0)); // R10

    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (op[3:1] == 3'b011)); // R5

    AST_STORE_K_ADDR: assert property (@(posedge clk) disable iff (rst)
        (op == 4'b0110) |-> (ram_we && ram_waddr == k)); // R5

    AST_READ_K_LATCH: assert property (@(posedge clk) disable iff (rst)
        (op == 4'b1000) |=> (ram_raddr == $past(k))); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op[3:1] != 3'b100) |=> $stable(ram_raddr)); // R6

    AST_JUMP_K: assert property (@(posedge clk) disable iff (rst)
        (op == 4'b1010) |=> (rom_addr == PW'($past(k)))); // R7

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (op[3:1] != 3'b101 && op[3:1] != 3'b110)
        |=> (rom_addr == $past(rom_addr) + PW'(1))); // R9

endmodule

bind nacc_core nacc_chk #(.DW(DW), .PW(PW)) u_chk (.*);

// File: tb/sim_nacc_core.sv
module sim_nacc_core;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] rom_addr;
    logic [7:0] rom_data;
    logic [3:0] ram_raddr;
    logic [3:0] ram_rdata;
    logic       ram_we;
    logic [3:0] ram_waddr;
    logic [3:0] ram_wdata;

    logic [7:0] rom  [16];
    logic [3:0] dram [16];
    logic [3:0] mref [16];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // Reference model state
    logic [3:0] m_pc, m_acc, m_adr;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rom_data  = rom[rom_addr];
    assign ram_rdata = dram[ram_raddr];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ram_we) dram[ram_waddr] <= ram_wdata;
    end

    nacc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .ram_raddr (ram_raddr),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        string s;
        case (op[3:1])
            3'b000: s = "R2";
            3'b001: s = "R3";
            3'b010: s = "R4";
            3'b011: s = "R5";
            3'b100: s = "R6";
            3'b101: s = "R7";
            3'b110: s = "R8";
            default: s = "R9";
        endcase
        if (op[0] && op[3:1] != 3'b111) s = {s, " R11"};
        return s;
    endfunction

    // Cycle-by-cycle reference model, compared on every falling edge.
    always @(negedge clk) begin
        if (rst) begin
            m_pc  = 4'd0;
            m_acc = 4'd0;
            m_adr = 4'd0;
        end else begin
            logic [7:0] ins;
            logic [3:0] op, kc, opnd;
            logic       ewe;
            int         act_v, exp_v;
            ins  = rom[m_pc];
            op   = ins[7:4];
            kc   = ins[3:0];
            opnd = op[0] ? mref[m_adr] : kc;
            ewe  = (op[3:1] == 3'b011);
            act_v = {rom_addr, ram_raddr, 3'b000, ram_we,
                     ram_we ? ram_waddr : 4'h0, ram_we ? ram_wdata : 4'h0};
            exp_v = {m_pc, m_adr, 3'b000, ewe,
                     ewe ? opnd : 4'h0, ewe ? m_acc : 4'h0};
            chk({"R1 ", tag_of(op)}, "pc/raddr/we/waddr/wdata", act_v, exp_v);
            case (op[3:1])
                3'b000: begin m_acc = opnd;         m_pc = m_pc + 4'd1; end
                3'b001: begin m_acc = m_acc + opnd; m_pc = m_pc + 4'd1; end
                3'b010: begin m_acc = m_acc - opnd; m_pc = m_pc + 4'd1; end
                3'b011: begin mref[opnd] = m_acc;   m_pc = m_pc + 4'd1; end
                3'b100: begin m_adr = opnd;         m_pc = m_pc + 4'd1; end
                3'b101: m_pc = opnd;
                3'b110: m_pc = (m_acc == 4'd0) ? opnd : m_pc + 4'd1;
                default: m_pc = m_pc + 4'd1;
            endcase
        end
    end

    task automatic rom_fill(input logic [7:0] v);
        for (int i = 0; i < 16; i++) rom[i] = v;
    endtask

    initial begin : watchdog
        wait (cyc > 5000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) begin
            dram[i] = 4'h0;
            mref[i] = 4'h0;
        end
        dram[15] = 4'h9;
        mref[15] = 4'h9;

        // Program exercising every operation and both flavours
        rom_fill(8'hF0);
        rom[0]  = 8'h05; // load 5
        rom[1]  = 8'h2D; // add 13 -> 2 (wrap)
        rom[2]  = 8'h43; // sub 3 -> 15 (wrap)
        rom[3]  = 8'h64; // store to 4
        rom[4]  = 8'h84; // read 4
        rom[5]  = 8'h37; // add memory, constant 7 ignored -> 14
        rom[6]  = 8'h90; // read memory -> address 15
        rom[7]  = 8'h71; // store memory -> ram[ram[15]] = ram[9]
        rom[8]  = 8'hC0; // jump-if-zero, not taken
        rom[9]  = 8'h5A; // sub memory (ram[15]=9)
        rom[10] = 8'hE3; // no-op
        rom[11] = 8'h00; // load 0
        rom[12] = 8'hCE; // jump-if-zero, taken to 14
        rom[13] = 8'hFF; // no-op, skipped
        rom[14] = 8'hBF; // jump memory -> 9

        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10", "rom_addr in reset", rom_addr, 0);
        chk("R10", "ram_we in reset", ram_we, 0);
        @(posedge clk); #1 rst = 1'b0;

        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R5", "ram[4] after constant store", dram[4], 15);
        chk("R5", "ram[9] after memory store", dram[9], 14);
        chk("R6", "latched read address", ram_raddr, 15);
        chk("R11", "ram[15] untouched", dram[15], 9);

        // Reset clears the accumulator and blocks writes
        @(posedge clk); #1 rst = 1'b1;
        rom_fill(8'hE0);
        rom[0] = 8'h63; // store to 3
        rom[1] = 8'hA0; // jump 0
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10", "rom_addr after reset", rom_addr, 0);
        chk("R10", "ram_raddr after reset", ram_raddr, 0);
        chk("R10", "ram_we held low in reset", ram_we, 0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        chk("R10", "store we after reset", ram_we, 1);
        chk("R10", "store addr after reset", ram_waddr, 3);
        chk("R10", "accumulator cleared", ram_wdata, 0);
        @(posedge clk); #1;

        // Increment loop
        rst = 1'b1;
        rom_fill(8'hF0);
        rom[0] = 8'h82; // read 2
        rom[1] = 8'h10; // load memory
        rom[2] = 8'h21; // add 1
        rom[3] = 8'h62; // store to 2
        rom[4] = 8'hA0; // jump 0
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        repeat (5 * 20) @(posedge clk);
        @(negedge clk);
        chk("R12", "ram[2] after 20 passes", dram[2], 20 % 16);
        chk("R7", "pc back at loop start", rom_addr, 0);

        for (int i = 0; i < 16; i++) begin
            chk("R5", $sformatf("ram[%0d] vs model", i), dram[i], mref[i]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule